// File: doc/BRIEF.md
# Branch Metric Dynamic Normalizer

This block sits between the branch metric unit and the add-compare-select (ACS) array of a state-parallel adaptive Viterbi decoder. For each decoding depth it receives every distinct branch metric and finds the smallest one. It also receives one "miss" flag per trellis state. A state raises its flag when it holds no survivor inside the threshold region next to the fixed path metric target. The block subtracts the smallest metric from every lane, and may subtract a small bias as well, then hands the signed result to the ACS array.

The bias is chosen with no search over path metrics. If every state reports a miss, all flags AND to one and the bias is the constant `BIAS_R`. That drags the path metrics down toward the target. Otherwise the bias is zero. The normalized metrics are then non-negative, and the smallest of them is exactly zero.

The miss flags presented with a set of metrics are the ACS results of the previous depth. Both are captured together in the same cycle. The minimum search and the bias reduction lie outside the recursive ACS loop, so they are pipelined freely. The block has a fixed latency of two registers.

Top module: `bm_normalizer`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` goes to 0 and every lane of `norm_out` goes to 0.
- R2: A vector accepted with `in_valid` = 1 at clock edge n shows up with `out_valid` = 1 after edge n+2. A cycle with `in_valid` = 0 at edge n gives `out_valid` = 0 after edge n+2.
- R3: If any bit of `thr_miss` is 0, each output lane equals its raw lane minus the minimum raw lane. The smallest output lane is then exactly 0, and no lane is negative.
- R4: If every bit of `thr_miss` is 1, each output lane equals its raw lane minus the minimum raw lane minus `BIAS_R`. The smallest output lane is then exactly -`BIAS_R`.
- R5: The bias for a vector is decided only by the `thr_miss` bits sampled in the same cycle as that vector's `in_valid`. Miss bits from earlier or later cycles, including cycles with `in_valid` = 0, have no effect on it.
- R6: Metrics and miss bits presented with `in_valid` = 0 are ignored. `norm_out` keeps its last value in every cycle where `out_valid` is 0.
- R7: Lane i of `norm_out` belongs to lane i of `bm_in`, whatever the lane order and whether or not values tie. Lane i sits at bits [i*BM_W +: BM_W] of `bm_in` and at bits [i*OUT_W +: OUT_W] of `norm_out`.
- R8: Raw metrics cover the full unsigned range 0 to 2^BM_W-1. Each output lane is two's complement with OUT_W = BM_W+1 bits, so both 2^BM_W-1 and -`BIAS_R` are exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new depth of branch metrics is present |
| bm_in | input | NUM_BM*BM_W | Unsigned raw branch metrics, lane i at [i*BM_W +: BM_W] |
| thr_miss | input | NUM_STATES | One per state: 1 = no survivor inside the threshold region at the previous depth |
| out_valid | output | 1 | Normalized metrics updated this cycle |
| norm_out | output | NUM_BM*OUT_W | Signed normalized metrics, lane i at [i*OUT_W +: OUT_W] |

## Verification
The bench sweeps every combination of four 4-bit lanes, with ties, zeros and all-maximum lanes among them. The bias changes from vector to vector, so a design that paired miss bits with the wrong depth would apply a bias to the wrong vector and be caught (R5). Idle cycles carry garbage metrics and all-ones miss bits. A design that loaded data without `in_valid`, or let idle miss bits steer the next bias, would move `norm_out` or pick up a stray -`BIAS_R`. A narrow output, or a lane swap in the tree, would show up as wrapped values at 15 and -2 or as outputs in the wrong lanes.

// File: rtl/bmn_pkg.sv
package bmn_pkg;
  typedef enum logic {
    BIAS_NONE = 1'b0,
    BIAS_PUSH = 1'b1
  } bias_sel_e;
endpackage

// File: rtl/bmn_min_tree.sv
module bmn_min_tree #(
  parameter int NUM_BM = 4,
  parameter int BM_W   = 4
) (
  input  logic [NUM_BM*BM_W-1:0] bm,
  output logic [BM_W-1:0]        bm_min
);
  localparam int DEPTH  = (NUM_BM > 1) ? $clog2(NUM_BM) : 0;
  localparam int LEAVES = 1 << DEPTH;

  for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
    localparam int N = LEAVES >> l;
    logic [BM_W-1:0] v [N];
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < N; j++) begin : g_j
        if (j < NUM_BM) begin : g_real
          assign v[j] = bm[j*BM_W +: BM_W];
        end else begin : g_pad
          assign v[j] = '1;
        end
      end
    end else begin : g_node
      for (genvar j = 0; j < N; j++) begin : g_j
        assign v[j] = (g_lvl[l-1].v[2*j] <= g_lvl[l-1].v[2*j+1]) ?
                      g_lvl[l-1].v[2*j] : g_lvl[l-1].v[2*j+1];
      end
    end
  end

  assign bm_min = g_lvl[DEPTH].v[0];
endmodule

// File: rtl/bmn_bias_pick.sv
module bmn_bias_pick
  import bmn_pkg::*;
#(
  parameter int NUM_STATES = 64
) (
  input  logic [NUM_STATES-1:0] thr_miss,
  output bias_sel_e             sel
);
  assign sel = (&thr_miss) ? BIAS_PUSH : BIAS_NONE;
endmodule

// File: rtl/bmn_lane_sub.sv
module bmn_lane_sub
  import bmn_pkg::*;
#(
  parameter int BM_W   = 4,
  parameter int OUT_W  = BM_W + 1,
  parameter int BIAS_R = 2
) (
  input  logic [BM_W-1:0]  raw,
  input  logic [BM_W-1:0]  bm_min,
  input  bias_sel_e        sel,
  output logic [OUT_W-1:0] norm
);
  localparam logic [OUT_W-1:0] BIAS_V = OUT_W'(BIAS_R);
  logic [OUT_W-1:0] bias;

  assign bias = (sel == BIAS_PUSH) ? BIAS_V : '0;
  assign norm = OUT_W'(raw) - OUT_W'(bm_min) - bias;
endmodule

// File: rtl/bm_normalizer.sv
module bm_normalizer
  import bmn_pkg::*;
#(
  parameter int NUM_BM     = 4,
  parameter int BM_W       = 4,
  parameter int NUM_STATES = 64,
  parameter int BIAS_R     = 2,
  parameter int OUT_W      = BM_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [NUM_BM*BM_W-1:0]  bm_in,
  input  logic [NUM_STATES-1:0]   thr_miss,
  output logic                    out_valid,
  output logic [NUM_BM*OUT_W-1:0] norm_out
);
  logic [BM_W-1:0]        min_c;
  bias_sel_e              sel_c;

  logic [NUM_BM*BM_W-1:0] s1_bm;
  logic [BM_W-1:0]        s1_min;
  bias_sel_e              s1_sel;
  logic                   s1_vld;
  logic [NUM_BM*OUT_W-1:0] norm_c;

  bmn_min_tree #(.NUM_BM(NUM_BM), .BM_W(BM_W)) u_min (
    .bm     (bm_in),
    .bm_min (min_c)
  );

  bmn_bias_pick #(.NUM_STATES(NUM_STATES)) u_bias (
    .thr_miss (thr_miss),
    .sel      (sel_c)
  );

  // Stage 1: metrics, their minimum and the bias choice of the same depth
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_bm  <= '0;
      s1_min <= '0;
      s1_sel <= BIAS_NONE;
    end else begin
      s1_vld <= in_valid;
      if (in_valid) begin
        s1_bm  <= bm_in;
        s1_min <= min_c;
        s1_sel <= sel_c;
      end
    end
  end

  for (genvar i = 0; i < NUM_BM; i++) begin : g_lane
    bmn_lane_sub #(.BM_W(BM_W), .OUT_W(OUT_W), .BIAS_R(BIAS_R)) u_sub (
      .raw    (s1_bm[i*BM_W +: BM_W]),
      .bm_min (s1_min),
      .sel    (s1_sel),
      .norm   (norm_c[i*OUT_W +: OUT_W])
    );
  end

  // Stage 2: registered outputs, held while no new depth arrives
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      norm_out  <= '0;
    end else begin
      out_valid <= s1_vld;
      if (s1_vld) begin
        norm_out <= norm_c;
      end
    end
  end
endmodule

// File: rtl/bmn_checker.sv
module bmn_checker #(
  parameter int NUM_BM     = 4,
  parameter int BM_W       = 4,
  parameter int NUM_STATES = 64,
  parameter int BIAS_R     = 2,
  parameter int OUT_W      = BM_W + 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [NUM_STATES-1:0]   thr_miss,
  input logic                    out_valid,
  input logic [NUM_BM*OUT_W-1:0] norm_out
);
  logic any_zero, any_negr, all_ge0, all_ge_negr;

  always_comb begin
    any_zero    = 1'b0;
    any_negr    = 1'b0;
    all_ge0     = 1'b1;
    all_ge_negr = 1'b1;
    for (int i = 0; i < NUM_BM; i++) begin
      if (int'($signed(norm_out[i*OUT_W +: OUT_W])) == 0)       any_zero = 1'b1;
      if (int'($signed(norm_out[i*OUT_W +: OUT_W])) == -BIAS_R) any_negr = 1'b1;
      if (int'($signed(norm_out[i*OUT_W +: OUT_W])) < 0)        all_ge0 = 1'b0;
      if (int'($signed(norm_out[i*OUT_W +: OUT_W])) < -BIAS_R)  all_ge_negr = 1'b0;
    end
  end

  AST_LATENCY_VALID: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid); // R2
  AST_LATENCY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid); // R2
  AST_NO_BIAS_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(&thr_miss, 2)) |-> (any_zero && all_ge0)); // R3
  AST_PUSH_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(&thr_miss, 2)) |-> (any_negr && all_ge_negr)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(norm_out)); // R6
endmodule

bind bm_normalizer bmn_checker #(
  .NUM_BM(NUM_BM), .BM_W(BM_W), .NUM_STATES(NUM_STATES),
  .BIAS_R(BIAS_R), .OUT_W(OUT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .thr_miss  (thr_miss),
  .out_valid (out_valid),
  .norm_out  (norm_out)
);

// File: tb/test_bm_normalizer.sv
module test_bm_normalizer;
  localparam int NUM_BM = 4;
  localparam int BM_W   = 4;
  localparam int NS     = 8;
  localparam int BIAS_R = 2;
  localparam int OUT_W  = BM_W + 1;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    in_valid = 1'b0;
  logic [NUM_BM*BM_W-1:0]  bm_in = '0;
  logic [NS-1:0]           thr_miss = '0;
  logic                    out_valid;
  logic [NUM_BM*OUT_W-1:0] norm_out;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bm_normalizer #(
    .NUM_BM(NUM_BM), .BM_W(BM_W), .NUM_STATES(NS), .BIAS_R(BIAS_R), .OUT_W(OUT_W)
  ) i_bm_normalizer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .bm_in(bm_in),
    .thr_miss(thr_miss), .out_valid(out_valid), .norm_out(norm_out)
  );

  bit    h_v [4];
  int    h_e [4][NUM_BM];
  string h_t [4];
  int    last_e [NUM_BM];
  int    cur [NUM_BM];
  int    cyc = 0;

  function automatic int lane_out(int i);
    return int'($signed(norm_out[i*OUT_W +: OUT_W]));
  endfunction

  task automatic check_out();
    int idx;
    string tag;
    bit mis;
    int bad_lane;
    idx = (cyc + 2) & 3;
    checks++;
    if (out_valid !== h_v[idx]) begin
      bad++;
      $display("FAIL R2 cycle %0d: out_valid=%0b expected %0b", cyc, out_valid, h_v[idx]);
    end
    tag = h_v[idx] ? h_t[idx] : "R6";
    mis = 1'b0;
    bad_lane = 0;
    for (int i = 0; i < NUM_BM; i++) begin
      if (!mis && lane_out(i) != (h_v[idx] ? h_e[idx][i] : last_e[i])) begin
        mis = 1'b1;
        bad_lane = i;
      end
    end
    checks++;
    if (mis) begin
      bad++;
      $display("FAIL %s cycle %0d lane %0d: got %0d expected %0d", tag, cyc, bad_lane,
               lane_out(bad_lane), h_v[idx] ? h_e[idx][bad_lane] : last_e[bad_lane]);
    end
    if (h_v[idx]) begin
      for (int i = 0; i < NUM_BM; i++) last_e[i] = h_e[idx][i];
    end
  endtask

  // One cycle: check what is due, then drive cur[] with the given miss bits
  task automatic step(input bit v, input logic [NS-1:0] miss, input string tag);
    int mn;
    int b;
    @(negedge clk);
    check_out();
    in_valid = v;
    thr_miss = miss;
    mn = 1 << BM_W;
    for (int i = 0; i < NUM_BM; i++) begin
      bm_in[i*BM_W +: BM_W] = BM_W'(cur[i]);
      if (cur[i] < mn) mn = cur[i];
    end
    b = (&miss) ? BIAS_R : 0;
    h_v[cyc & 3] = v;
    h_t[cyc & 3] = tag;
    for (int i = 0; i < NUM_BM; i++) h_e[cyc & 3][i] = cur[i] - mn - b;
    cyc++;
  endtask

  task automatic set4(int a, int b, int c, int d);
    cur[0] = a; cur[1] = b; cur[2] = c; cur[3] = d;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin : main
    bit prev_all;
    bit all_m;
    logic [NS-1:0] miss;
    string tag;
    for (int i = 0; i < 4; i++) begin
      h_v[i] = 1'b0;
      h_t[i] = "R6";
      for (int j = 0; j < NUM_BM; j++) h_e[i][j] = 0;
    end
    for (int j = 0; j < NUM_BM; j++) last_e[j] = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || norm_out !== '0) begin
      bad++;
      $display("FAIL R1: out_valid=%0b norm_out=%h expected 0 and 0", out_valid, norm_out);
    end
    rst = 1'b0;

    // Exhaustive sweep over four 4-bit lanes (R3 R4 R5 R7 R8)
    prev_all = 1'b0;
    for (int k = 0; k < (1 << (NUM_BM*BM_W)); k++) begin
      if (k % 257 == 0) begin
        for (int i = 0; i < NUM_BM; i++) cur[i] = (k * 7 + i * 5) & 15;
        step(1'b0, '1, "R6");   // garbage, all-miss: must not steer next bias (R5)
        prev_all = 1'b1;
      end
      for (int i = 0; i < NUM_BM; i++) cur[i] = (k >> (BM_W*i)) & 15;
      all_m = (k % 5 == 0);
      miss = all_m ? '1 : ~(NS'(1) << (k % NS));
      if (all_m != prev_all) tag = "R5";
      else tag = all_m ? "R4" : "R3";
      step(1'b1, miss, tag);
      prev_all = all_m;
    end

    // R7: lane order with ties, no bias
    set4(3, 9, 3, 12);  step(1'b1, 8'hFE, "R7");
    set4(12, 3, 9, 3);  step(1'b1, 8'h7F, "R7");
    // R8: range extremes with bias
    set4(15, 15, 15, 15); step(1'b1, '1, "R8");
    set4(0, 15, 0, 15);   step(1'b1, '1, "R8");
    set4(0, 15, 0, 15);   step(1'b1, 8'h00, "R8");
    // R6: idle cycles with changing garbage keep the last output
    set4(1, 2, 3, 4); step(1'b0, 8'h00, "R6");
    set4(9, 0, 7, 5); step(1'b0, '1, "R6");
    step(1'b0, '1, "R6");
    step(1'b0, '1, "R6");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule